// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Bridge

This block connects a clocked request/response port to an external asynchronous static RAM of 256K 16-bit words. A requester offers a transfer with a valid/ready handshake. The transfer carries a direction bit, an 18-bit word address, a 16-bit write word and a two-bit lane mask. The bridge then runs one memory cycle on the active-low strobes. It holds the strobes for a whole number of clock cycles that covers the memory access time. It ends each transfer with a one-cycle response pulse, and for reads that pulse carries the captured word.

Each 8-bit half of the word is written and read under its own active-low lane enable. The bridge drives the shared data bus only while a write is in progress, and it releases the bus a cycle after the write strobe ends. When no transfer is open, every strobe is high, which leaves the memory in its low-power standby state. A transfer whose lane mask is empty finishes on the spot without touching the memory. The access time and the clock period are parameters, so one design fits both the fast and the slow speed grades.

The sequencer has four states:
- IDLE: standby, ready to accept a request.
- RD_STROBE: a read access is in progress.
- WR_STROBE: the write pulse is held low.
- WR_HOLD: write data is still driven after the write strobe has risen.

Transitions:
- IDLE to RD_STROBE on an accepted read with a non-empty mask.
- IDLE to WR_STROBE on an accepted write with a non-empty mask.
- IDLE to IDLE on an accepted empty-mask request, with a response on the next cycle.
- RD_STROBE to IDLE when the wait count ends. The bus is captured at that edge.
- WR_STROBE to WR_HOLD when the wait count ends.
- WR_HOLD to IDLE after one cycle.

Top module: `sram_bridge`

## Requirements
- R1: After reset and in every cycle with no transfer open, mem_ce_n, mem_we_n, mem_oe_n and both bits of mem_be_n are 1 and mem_dq_oe is 0.
- R2: A write with a non-empty mask holds mem_ce_n=0 and mem_we_n=0 together, with mem_oe_n=1, from the cycle after acceptance. Through the whole cycle, mem_addr equals the request address and mem_dq_out equals the request write word.
- R3: While a transfer is open, mem_be_n[0] is 0 exactly when req_mask[0] was 1, and mem_be_n[1] is 0 exactly when req_mask[1] was 1. Bit 0 governs data bits 7:0 and bit 1 governs data bits 15:8.
- R4: A read with a non-empty mask holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 from the cycle after acceptance. mem_dq_in is sampled at the clock edge that ends the last strobe cycle.
- R5: mem_dq_oe is 1 only in cycles where mem_ce_n=0 and mem_oe_n=1.
- R6: After mem_we_n rises at the end of a write strobe, mem_dq_oe stays 1 for exactly one more cycle and then drops to 0.
- R7: The strobe phase of every memory cycle lasts WAIT_CYC = max(1, ceil(ACCESS_NS / CLK_PERIOD_NS)) cycles, which is 6 with the defaults 55 and 10.
- R8: req_ready is 0 from the cycle after a non-empty request is accepted until the response cycle, and is 1 in the response cycle.
- R9: A request with req_mask=00 causes no strobe activity. It gives rsp_valid=1 with rsp_rdata=0 in the next cycle, and req_ready stays 1.
- R10: rsp_valid is 1 for one cycle at the end of each transfer. For a read that cycle follows the last strobe cycle; for a write it follows the hold cycle. rsp_rdata carries the sampled lanes, and it carries 0 on lanes not enabled and for writes.
- R11: mem_dq_oe is 0 in the cycle right after any cycle with mem_oe_n=0, so there is a turnaround cycle between a read and a following write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write word |
| req_mask | input | 2 | Lane mask; bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read word, zero on lanes not enabled |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low; bit 0 low lane, bit 1 high lane |
| mem_addr | output | 18 | Memory word address |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | 1 = bridge drives the data bus |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
The assertions check the following on every clock:
- the standby strobe levels;
- that bus drive and output enable never overlap;
- the one-cycle write data hold and the turnaround after a read;
- that the address stays stable through a strobe;
- that lane enables follow the accepted mask;
- the exact strobe length;
- the immediate response to an empty mask.

Only the bench scenarios can show the values themselves. Such scenarios cover:
- that a word written to one lane leaves the other lane unchanged when read back;
- that a masked-out lane returns zero even though the memory puts junk on it;
- that an empty-mask write leaves memory untouched;
- that back-to-back requests are accepted on the first free cycle.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RD_STROBE = 2'd1,
        ST_WR_STROBE = 2'd2,
        ST_WR_HOLD   = 2'd3
    } bridge_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CYCLES = 6,
    parameter int CNT_W  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(CYCLES - 1);
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = run && (cnt_q == '0);

    // R7: the down-counter never holds more than the loaded wait
    p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CYCLES - 1));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic mask_zero,
    input  logic timer_last,
    output logic req_ready,
    output logic accept,
    output logic timer_load,
    output logic timer_run,
    output logic lanes_active,
    output logic capture,
    output logic clear_rsp,
    output logic rsp_fire,
    output logic ce_n,
    output logic we_n,
    output logic oe_n,
    output logic drive
);

    bridge_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && !mask_zero) begin
                    state_d = req_write ? ST_WR_STROBE : ST_RD_STROBE;
                end
            end
            ST_RD_STROBE: begin
                if (timer_last) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WR_STROBE: begin
                if (timer_last) begin
                    state_d = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready    = 1'b0;
        accept       = 1'b0;
        timer_load   = 1'b0;
        timer_run    = 1'b0;
        lanes_active = 1'b1;
        capture      = 1'b0;
        clear_rsp    = 1'b0;
        rsp_fire     = 1'b0;
        ce_n         = 1'b0;
        we_n         = 1'b1;
        oe_n         = 1'b1;
        drive        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready    = 1'b1;
                lanes_active = 1'b0;
                ce_n         = 1'b1;
                accept       = req_valid;
                timer_load   = req_valid;
                if (req_valid && mask_zero) begin
                    rsp_fire  = 1'b1;
                    clear_rsp = 1'b1;
                end
            end
            ST_RD_STROBE: begin
                oe_n      = 1'b0;
                timer_run = 1'b1;
                if (timer_last) begin
                    capture  = 1'b1;
                    rsp_fire = 1'b1;
                end
            end
            ST_WR_STROBE: begin
                we_n      = 1'b0;
                drive     = 1'b1;
                timer_run = 1'b1;
            end
            ST_WR_HOLD: begin
                drive     = 1'b1;
                rsp_fire  = 1'b1;
                clear_rsp = 1'b1;
            end
            default: begin
                ce_n         = 1'b1;
                lanes_active = 1'b0;
            end
        endcase
    end

    // R5: the bus is never driven while output enable is low or the chip is idle
    p_bus_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> (oe_n && !ce_n));

    // R2: the write strobe comes only with chip enable and without output enable
    p_write_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!ce_n && oe_n));

    // R4: the read strobe comes only with chip enable and write enable high
    p_read_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!ce_n && we_n));

    // R6: data stays driven in the cycle where the write strobe rises
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(we_n) && !ce_n) |-> drive);

    // R6: drive lasts no longer than one cycle past the write strobe
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && we_n) |=> !drive);

    // R11: a cycle with output enable low is never followed by bus drive
    p_turn_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |=> !drive);

    // R8: a real access takes the ready signal down in the next cycle
    p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !mask_zero) |=> !req_ready);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              capture,
    input  logic              clear,
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] dq_in,
    output logic [LANES-1:0]  be_n,
    output logic [DATA_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;

        assign be_n[g] = !(active && mask[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (capture) begin
                lane_q <= mask[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
            end else if (clear) begin
                lane_q <= '0;
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_q;

        // R10: a lane outside the mask comes back as zero
        p_lane_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (capture && !mask[g]) |=> (rdata[g*LANE_W +: LANE_W] == '0));
    end

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int LANE_W        = 8,
    parameter int LANES         = 2,
    parameter int CLK_PERIOD_NS = 10,
    parameter int ACCESS_NS     = 55,
    localparam int DATA_W   = LANE_W * LANES,
    localparam int WAIT_CYC = at_least_one(ceil_div(ACCESS_NS, CLK_PERIOD_NS)),
    localparam int CNT_W    = $clog2(WAIT_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    logic              accept, timer_load, timer_run, timer_last;
    logic              lanes_active, capture, clear_rsp, rsp_fire;
    logic              mask_zero;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;

    assign mask_zero = (req_mask == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept && !mask_zero) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= rsp_fire;
        end
    end

    sram_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .mask_zero    (mask_zero),
        .timer_last   (timer_last),
        .req_ready    (req_ready),
        .accept       (accept),
        .timer_load   (timer_load),
        .timer_run    (timer_run),
        .lanes_active (lanes_active),
        .capture      (capture),
        .clear_rsp    (clear_rsp),
        .rsp_fire     (rsp_fire),
        .ce_n         (mem_ce_n),
        .we_n         (mem_we_n),
        .oe_n         (mem_oe_n),
        .drive        (mem_dq_oe)
    );

    sram_wait_timer #(
        .CYCLES (WAIT_CYC),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .run   (timer_run),
        .last  (timer_last)
    );

    sram_lane_ctrl #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (lanes_active),
        .capture (capture),
        .clear   (clear_rsp),
        .mask    (mask_q),
        .dq_in   (mem_dq_in),
        .be_n    (mem_be_n),
        .rdata   (rsp_rdata)
    );

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    // Strobe-length monitor for R7
    logic            strobe_on;
    logic [CNT_W:0]  strobe_run_q;

    assign strobe_on = !mem_ce_n && (!mem_we_n || !mem_oe_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_run_q <= '0;
        end else if (strobe_on) begin
            strobe_run_q <= strobe_run_q + 1'b1;
        end else begin
            strobe_run_q <= '0;
        end
    end

    // R7: every finished strobe phase lasted exactly WAIT_CYC cycles
    p_strobe_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_on && (strobe_run_q != '0)) |-> (strobe_run_q == (CNT_W+1)'(WAIT_CYC)));

    // R1: chip deselected means every strobe high and the bus released
    p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> ((&mem_be_n) && mem_we_n && mem_oe_n && !mem_dq_oe));

    // R3: lane enables in the first access cycle mirror the accepted mask
    p_lane_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_mask != '0)) |=> (mem_be_n == ~$past(req_mask)));

    // R2: the address does not move while the chip stays selected
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R9: an empty mask answers at once with zero data and no chip select
    p_zero_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_mask == '0)) |=> (rsp_valid && mem_ce_n && (rsp_rdata == '0)));

endmodule

// File: tb/test_sram_bridge.sv
module test_sram_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int T_CLK_NS   = 10;
    localparam int T_ACC_NS   = 55;
    localparam int W          = (T_ACC_NS + T_CLK_NS - 1) / T_CLK_NS;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [17:0] mem_addr;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_bridge #(
        .CLK_PERIOD_NS (T_CLK_NS),
        .ACCESS_NS     (T_ACC_NS)
    ) i_sram_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_mask   (req_mask),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_be_n   (mem_be_n),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Pin-level memory: lane data on enabled read lanes, junk elsewhere
    logic [15:0] sram   [256];
    logic [15:0] shadow [256];

    always_comb begin
        for (int i = 0; i < 2; i++) begin
            mem_dq_in[i*8 +: 8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[i])
                                  ? sram[mem_addr[7:0]][i*8 +: 8] : 8'hA5;
        end
    end

    always @(posedge clk) begin
        if (rst_n && !mem_ce_n && !mem_we_n) begin
            for (int i = 0; i < 2; i++) begin
                if (!mem_be_n[i]) sram[mem_addr[7:0]][i*8 +: 8] = mem_dq_out[i*8 +: 8];
            end
        end
    end

    // Behavioural reference: phase 0 idle, 1..W strobe, W+1 write hold
    int          m_phase = 0;
    int          m_kind  = 0;   // 0 none, 1 read, 2 write
    bit          m_rsp_v = 1'b0;
    bit          m_zero  = 1'b0;
    logic [15:0] m_rdata = '0;
    logic [17:0] m_addr  = '0;
    logic [15:0] m_wdata = '0;
    logic [1:0]  m_mask  = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_kind = 0; m_rsp_v = 1'b0; m_zero = 1'b0; m_rdata = '0;
        end else begin
            m_rsp_v = 1'b0;
            m_zero  = 1'b0;
            if (m_phase == 0) begin
                if (req_valid) begin
                    if (req_mask == 2'b00) begin
                        m_rsp_v = 1'b1; m_zero = 1'b1; m_rdata = '0;
                    end else begin
                        m_kind  = req_write ? 2 : 1;
                        m_addr  = req_addr; m_wdata = req_wdata; m_mask = req_mask;
                        m_phase = 1;
                    end
                end
            end else if (m_kind == 1) begin
                if (m_phase == W) begin
                    for (int i = 0; i < 2; i++)
                        m_rdata[i*8 +: 8] = m_mask[i] ? shadow[m_addr[7:0]][i*8 +: 8] : 8'h00;
                    m_rsp_v = 1'b1; m_phase = 0; m_kind = 0;
                end else begin
                    m_phase++;
                end
            end else begin
                if (m_phase == W + 1) begin
                    for (int i = 0; i < 2; i++)
                        if (m_mask[i]) shadow[m_addr[7:0]][i*8 +: 8] = m_wdata[i*8 +: 8];
                    m_rdata = '0; m_rsp_v = 1'b1; m_phase = 0; m_kind = 0;
                end else begin
                    m_phase++;
                end
            end
        end
    end

    // Cycle-by-cycle comparison away from the active edge
    bit prev_oe_low = 1'b0;
    int strobe_len  = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit   idle, rd, wr_pulse, wr_any;
            string tag;
            idle     = (m_phase == 0);
            rd       = (m_kind == 1) && !idle;
            wr_pulse = (m_kind == 2) && (m_phase >= 1) && (m_phase <= W);
            wr_any   = (m_kind == 2) && !idle;
            tag      = idle ? "R1" : (rd ? "R4" : "R2");
            chk(req_ready == idle, "R8 req_ready", 32'(req_ready), 32'(idle));
            chk(mem_ce_n == idle, {tag, " ce_n"}, 32'(mem_ce_n), 32'(idle));
            chk(mem_we_n == !wr_pulse, {tag, " we_n"}, 32'(mem_we_n), 32'(!wr_pulse));
            chk(mem_oe_n == !rd, {tag, " oe_n"}, 32'(mem_oe_n), 32'(!rd));
            chk(mem_be_n == (idle ? 2'b11 : ~m_mask), "R3 be_n", 32'(mem_be_n),
                32'(idle ? 2'b11 : ~m_mask));
            chk(mem_dq_oe == wr_any, (m_phase == W + 1) ? "R6 dq_oe hold" : "R5 dq_oe",
                32'(mem_dq_oe), 32'(wr_any));
            if (!idle) chk(mem_addr == m_addr, {tag, " addr"}, 32'(mem_addr), 32'(m_addr));
            if (wr_any) chk(mem_dq_out == m_wdata, "R2 dq_out", 32'(mem_dq_out), 32'(m_wdata));
            chk(rsp_valid == m_rsp_v, m_zero ? "R9 rsp_valid" : "R10 rsp_valid",
                32'(rsp_valid), 32'(m_rsp_v));
            if (m_rsp_v) chk(rsp_rdata == m_rdata, m_zero ? "R9 rsp_rdata" : "R10 rsp_rdata",
                32'(rsp_rdata), 32'(m_rdata));
            if (prev_oe_low) chk(!mem_dq_oe, "R11 turnaround", 32'(mem_dq_oe), 32'd0);
            prev_oe_low = !mem_oe_n;
            if (!mem_ce_n && (!mem_we_n || !mem_oe_n)) begin
                strobe_len++;
            end else if (strobe_len != 0) begin
                chk(strobe_len == W, "R7 strobe length", 32'(strobe_len), 32'(W));
                strobe_len = 0;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Called at a negedge; returns at the negedge after acceptance
    task automatic do_req(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        bit acc;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        forever begin
            acc = req_ready;
            @(negedge clk);
            if (acc) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            sram[i]   = 16'(i * 257) ^ 16'h3C00;
            shadow[i] = 16'(i * 257) ^ 16'h3C00;
        end
        idle_cycles(3);
        // R1: reset state at the ports
        chk(mem_ce_n && mem_we_n && mem_oe_n && (mem_be_n == 2'b11), "R1 reset strobes",
            {28'd0, mem_ce_n, mem_we_n, mem_oe_n, &mem_be_n}, 32'hF);
        chk(!mem_dq_oe, "R1 reset bus release", 32'(mem_dq_oe), 32'd0);
        chk(!rsp_valid, "R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        idle_cycles(2);
        chk(req_ready, "R8 ready after reset", 32'(req_ready), 32'd1);

        // full-word write and read
        do_req(1'b1, 18'h00010, 16'h1234, 2'b11);
        idle_cycles(W + 3);
        do_req(1'b0, 18'h00010, 16'h0000, 2'b11);
        idle_cycles(W + 3);
        // single-lane writes (R3) and masked reads (R10)
        do_req(1'b1, 18'h00010, 16'hABCD, 2'b01);
        idle_cycles(W + 3);
        do_req(1'b1, 18'h00010, 16'h9900, 2'b10);
        idle_cycles(W + 3);
        do_req(1'b0, 18'h00010, 16'h0000, 2'b01);
        idle_cycles(W + 3);
        do_req(1'b0, 18'h00010, 16'h0000, 2'b10);
        idle_cycles(W + 3);
        // R9: empty-mask write must not alter the word
        do_req(1'b1, 18'h00010, 16'hFFFF, 2'b00);
        idle_cycles(3);
        do_req(1'b0, 18'h00010, 16'h0000, 2'b11);
        idle_cycles(W + 3);
        chk(sram[8'h10] == 16'h99CD, "R9 memory untouched", 32'(sram[8'h10]), 32'h99CD);
        // address extremes
        do_req(1'b1, 18'h3FFFF, 16'h5AA5, 2'b11);
        idle_cycles(W + 3);
        chk(sram[8'hFF] == 16'h5AA5, "R2 top address write", 32'(sram[8'hFF]), 32'h5AA5);
        do_req(1'b0, 18'h3FFFF, 16'h0000, 2'b11);
        do_req(1'b0, 18'h00000, 16'h0000, 2'b11);
        // back-to-back read, write, read; then two empty-mask reads
        do_req(1'b0, 18'h00020, 16'h0000, 2'b11);
        do_req(1'b1, 18'h00020, 16'hC3C3, 2'b11);
        do_req(1'b0, 18'h00020, 16'h0000, 2'b10);
        do_req(1'b0, 18'h00021, 16'h0000, 2'b00);
        do_req(1'b0, 18'h00022, 16'h0000, 2'b00);
        idle_cycles(W + 4);
        chk(sram[8'h20] == 16'hC3C3, "R3 back-to-back write", 32'(sram[8'h20]), 32'hC3C3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule